// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Counter

This block is a 16-bit up-counter with two capture/compare channels. The counter advances once per clock, or once per valid edge seen on an external event input. An edge detector sits in front of that input and of each channel's capture input. Each detector can be set to ignore the input or to react to rising, falling or both edges. External inputs pass through a two-flop synchronizer before edge detection.

Each channel works in one of two modes. In compare mode, software writes a value that moves into a hidden buffer. The channel pulses its own interrupt line when the counter reaches the buffered value. If the write happens while the counter runs, the buffer takes the new value only at the next wrap. In capture mode, the channel stores the counter value when a valid edge appears on its capture input, and pulses its interrupt line.

While the counter is stopped it holds all-ones internally, and the readback register shows zero. A small word-wide register port handles configuration and readback. Reads on this port return data one cycle after the request.

Top module: `cct_timer_top`

## Requirements
- R1: After synchronous reset, the control word, the counter readback and both channel registers read 0, and both interrupt outputs are low.
- R2: While the run bit (control bit 0) is 0, the counter holds 16'hFFFF internally and a read of the counter (address 1) returns 0. In the first read cycle after run is set, before any count has occurred, the readback shows 16'hFFFF.
- R3: With the source bit (control bit 1) at 0 and run at 1, the counter advances by one every clock. The first count takes it from 16'hFFFF to 0, and it wraps from 16'hFFFF to 0.
- R4: With the source bit at 1, the counter advances once per valid edge of the event input. The valid edge is chosen by control bits [3:2]: 0 none, 1 rising, 2 falling, 3 both.
- R5: In compare mode (channel mode bit 0), a write to a channel register while run is 0 loads the hidden buffer at once. The channel interrupt pulses in the same cycle the counter shows the buffered value.
- R6: A compare write while run is 1 does not change the buffer before the next wrap. Matching keeps using the old value until that wrap, and the new value takes effect from the wrap on.
- R7: Each channel drives its own interrupt output. A compare match pulse lasts exactly one cycle.
- R8: In capture mode (channel mode bit 1), a valid edge on the channel's capture input stores the counter value into the channel register and gives a one-cycle interrupt pulse. The valid edge is chosen by the channel's 2-bit field, coded as in R4. Edges that are not selected have no effect.
- R9: The hidden buffers are not visible. A read of a channel register returns the last written (or captured) value, even while a pending compare value is not yet in use.
- R10: Register map: address 0 is control, address 1 is counter readback, addresses 2 and 3 are channels 0 and 1. Control holds 10 bits: run at bit 0, source at bit 1, event edge at [3:2], channel i mode at bit 4+i, and channel i capture edge at [7+2i:6+2i]. Upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data valid the next cycle |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| ev_in | input | 1 | External count event input (asynchronous) |
| cap_in | input | 2 | Per-channel capture inputs (asynchronous) |
| irq | output | 2 | Per-channel interrupt pulses |

## Verification
Embedded properties check on every cycle that:
- a stopped counter sits at all-ones and reads back as zero;
- each count step is exactly one;
- an event source set to no edge never moves the counter;
- a running buffer stays fixed between wraps;
- compare pulses last one cycle;
- a capture stores the counter value of the cycle before.

Only the bench scenarios can show the cycle-exact timing of a match against the counter. They also show the deferred buffer taking effect after a full wrap, edge counts for each detector mode, and capture spacing that tracks input timing.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det
  import cct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  edge_sel_e sel,
  output logic      hit
);
  // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], din};
  end

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_q_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         cap_mode_i,
  input  logic         cap_hit_i,
  output logic [W-1:0] val_o,
  output logic         irq_o
);
  logic [W-1:0] buf_q, buf_nxt;
  logic         pend_q;

  always_comb begin
    buf_nxt = buf_q;
    if (wr_i && !run_i)       buf_nxt = wdata_i;
    else if (wrap_i && pend_q) buf_nxt = val_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_o  <= '0;
      buf_q  <= '0;
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      buf_q <= buf_nxt;
      if (wr_i)        pend_q <= run_i;
      else if (wrap_i) pend_q <= 1'b0;
      if (cap_mode_i && cap_hit_i) val_o <= cnt_q_i;
      else if (wr_i)               val_o <= wdata_i;
      if (cap_mode_i) irq_o <= cap_hit_i;
      else            irq_o <= run_i && tick_i && (cnt_nxt_i == buf_nxt);
    end
  end

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_i && !wrap_i) |=> $stable(buf_q)); // R6
  AST_CMP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!cap_mode_i && irq_o) |=> !irq_o); // R7
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
    (cap_mode_i && cap_hit_i) |=> (val_o == $past(cnt_q_i))); // R8
endmodule

// File: rtl/cct_timer_top.sv
module cct_timer_top
  import cct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NCH    = 2,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              ev_in,
  input  logic [NCH-1:0]    cap_in,
  output logic [NCH-1:0]    irq
);
  localparam int MODE_LSB = 4;
  localparam int EDGE_LSB = MODE_LSB + NCH;
  localparam int CTRL_W   = EDGE_LSB + 2 * NCH;
  localparam int CH_BASE  = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              run, src_ext, ev_hit, tick, wrap;
  logic [CNT_W-1:0]  ch_val [NCH];
  logic [CNT_W-1:0]  rd_mux;

  assign run     = ctrl_q[0];
  assign src_ext = ctrl_q[1];

  cct_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ev_det (
    .clk(clk), .rst(rst), .din(ev_in),
    .sel(edge_sel_e'(ctrl_q[3:2])), .hit(ev_hit)
  );

  assign tick = run && (src_ext ? ev_hit : 1'b1);
  assign wrap = tick && (cnt_q == '1);

  always_comb begin
    if (!run)      cnt_nxt = '1;
    else if (tick) cnt_nxt = cnt_q + 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '1;
    end else begin
      cnt_q <= cnt_nxt;
      if (wr_en && addr == ADDR_W'(0)) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cap_hit;
    cct_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_cap_det (
      .clk(clk), .rst(rst), .din(cap_in[i]),
      .sel(edge_sel_e'(ctrl_q[EDGE_LSB + 2*i +: 2])), .hit(cap_hit)
    );
    cct_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr_i(wr_en && addr == ADDR_W'(CH_BASE + i)),
      .wdata_i(wdata), .run_i(run), .tick_i(tick), .wrap_i(wrap),
      .cnt_q_i(cnt_q), .cnt_nxt_i(cnt_nxt),
      .cap_mode_i(ctrl_q[MODE_LSB + i]), .cap_hit_i(cap_hit),
      .val_o(ch_val[i]), .irq_o(irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(0))      rd_mux = CNT_W'(ctrl_q);
    else if (addr == ADDR_W'(1)) rd_mux = run ? cnt_q : '0;
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(CH_BASE + i)) rd_mux = ch_val[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_STOP_FULL: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '1)); // R2
  AST_STOP_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(1) && !run) |=> (rdata == '0)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
  AST_EVENT_NONE: assert property (@(posedge clk) disable iff (rst)
    (run && src_ext && ctrl_q[3:2] == 2'd0) |=> $stable(cnt_q)); // R4
endmodule

// File: tb/tb_cct_timer_top.sv
module tb_cct_timer_top;
  logic        clk = 1'b0;
  logic        rst, wr_en, rd_en, ev_in;
  logic [1:0]  addr, cap_in, irq;
  logic [15:0] wdata, rdata;
  int checks = 0, fails = 0, cyc = 0;

  cct_timer_top dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_in(ev_in), .cap_in(cap_in), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // event-count vectors: edge mode, pulses, expected readback
  localparam logic [1:0]  EV_MODE [6] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd3, 2'd1};
  localparam int          EV_PULS [6] = '{3, 3, 3, 3, 1, 1};
  localparam logic [15:0] EV_EXP  [6] = '{16'd2, 16'd2, 16'd5, 16'hFFFF, 16'd1, 16'd0};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = rdata; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, c1, c2, c3;
    int t0, t1, t2, t3, n;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ev_in = 1'b0; cap_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R1 reg", 32'(v), 32'd0);
    end

    // R10 control readback with upper bits dropped
    wr(2'd0, 16'hFFFE); rd(2'd0, v); check("R10 ctrl", 32'(v), 32'h03FE);
    wr(2'd0, 16'h0000);

    // R4 event counting, table-driven
    for (int e = 0; e < 6; e++) begin
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0003 | (16'(EV_MODE[e]) << 2));
      for (int p = 0; p < EV_PULS[e]; p++) begin
        ev_in = 1'b1; repeat (4) @(negedge clk);
        ev_in = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      rd(2'd1, v); check("R4 event count", 32'(v), 32'(EV_EXP[e]));
    end

    // R2 stopped reads zero
    wr(2'd0, 16'h0000); rd(2'd1, v); check("R2 stopped read", 32'(v), 32'd0);

    // R5 / R7 compare from stopped write
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0001);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R5 irq0 timing", 32'(irq[0]), 32'(k == 6));
      check("R7 irq1 separate", 32'(irq[1]), 32'(k == 1));
    end

    // R2 / R3 restart from all-ones
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001);
    rd(2'd1, v); check("R2 pre-count ones", 32'(v), 32'hFFFF);
    rd(2'd1, v); check("R3 first count", 32'(v), 32'd0);
    rd(2'd1, v); check("R3 step", 32'(v), 32'd1);

    // R6 / R9 / R3 deferred buffer across a wrap
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h8000);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'd3);
    t0 = cyc; n = 0;
    while (!irq[0] && n < 70000) begin @(negedge clk); n++; end
    check("R6 old buffer match", 32'(cyc - t0), 32'd32768);
    rd(2'd2, v); check("R9 reg shows new", 32'(v), 32'd3);
    n = 0;
    while (!irq[0] && n < 70000) begin @(negedge clk); n++; end
    check("R6 new value after wrap", 32'(cyc - t0), 32'd65539);

    // R8 capture, rising edge on channel 1
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0121);
    repeat (5) @(negedge clk);
    cap_in[1] = 1'b1; t1 = cyc;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check("R8 capture pulse", 32'(irq[1]), 32'(k == 3));
    end
    rd(2'd3, c1);
    cap_in[1] = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, v); check("R8 falling ignored", 32'(v), 32'(c1));
    repeat (3) @(negedge clk);
    cap_in[1] = 1'b1; t2 = cyc;
    repeat (5) @(negedge clk);
    rd(2'd3, c2); check("R8 capture spacing", 32'(16'(c2 - c1)), 32'(16'(t2 - t1)));
    wr(2'd0, 16'h0321);
    repeat (4) @(negedge clk);
    cap_in[1] = 1'b0; t3 = cyc;
    repeat (5) @(negedge clk);
    rd(2'd3, c3); check("R8 both-edge fall", 32'(16'(c3 - c1)), 32'(16'(t3 - t1)));

    finish_run();
  end
endmodule